// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen 32-bit general registers of a processor core together with the shadow copies that each privilege mode owns. A 5-bit mode code selects one of seven modes. When the code changes, the block saves the live banked registers into the slot of the mode being left. It then fills them from the slot of the mode being entered, all within one clock edge. Datapath logic sees only the active view, through two combinational read ports and one write port.

A privileged routine that must touch the unprivileged copies of the banked registers uses a separate user-view port. It does not need to leave its own mode to do so. A saved-status port reads and writes the saved copy of the status word that belongs to the current mode. A mode request naming an unknown code raises an error flag and leaves every register and the mode untouched. How the status flags are worked out is not part of this block.

Top module: `banked_regfile`

## Requirements
- R1: After synchronous reset, `cur_mode` is 5'b11111 (System), every active and shadow register reads zero, `saved_rdata` is zero and `mode_err` is low.
- R2: The two read ports return the addressed active register combinationally and independently. A write through `wr_en`/`wr_addr`/`wr_data` is visible on both read ports from the cycle after the clock edge.
- R3: Valid mode codes are User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undefined 11011 and System 11111. A request with a valid code updates `cur_mode` at the next edge, and the new mode's registers appear on the read ports in the following cycle.
- R4: R13 and R14 are banked six ways. User and System share one pair. Supervisor, Abort, Undefined, IRQ and FIQ each keep a private pair that survives visits to other modes.
- R5: R8 to R12 have two copies. FIQ uses one copy, and every other mode shares the second.
- R6: Supervisor, Abort, Undefined, IRQ and FIQ each keep their own saved status word, reached through `saved_we`/`saved_wdata`/`saved_rdata` and preserved across mode changes. In User and System, `saved_rdata` reads zero and `saved_we` has no effect.
- R7: A request with any code outside the R3 list sets `mode_err` high for exactly the following cycle. It leaves `cur_mode`, the active registers and the saved status unchanged.
- R8: A user-view access to R13 or R14 reaches the active register in User or System, and the shared User/System pair in any other mode.
- R9: A user-view access to R8 to R12 in FIQ mode reaches the non-FIQ copy. In any other mode it reaches the active register.
- R10: A user-view access to R0 to R7 or R15 always reaches the active register. If the write port and the user-view port write the same active register in one cycle, the write port's value is kept.
- R11: In any cycle with `mode_req` high, the write port, the user-view write and the saved-status write are all ignored.
- R12: A request naming the current mode changes neither the registers nor `cur_mode`, and does not raise `mode_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 4 | Read port A register number |
| rd_data_a | output | DATA_W | Read port A data |
| rd_addr_b | input | 4 | Read port B register number |
| rd_data_b | output | DATA_W | Read port B data |
| wr_en | input | 1 | Active-register write enable |
| wr_addr | input | 4 | Active-register write number |
| wr_data | input | DATA_W | Active-register write data |
| usr_addr | input | 4 | User-view register number |
| usr_we | input | 1 | User-view write enable |
| usr_wdata | input | DATA_W | User-view write data |
| usr_rdata | output | DATA_W | User-view read data |
| mode_req | input | 1 | Mode change request strobe |
| mode_code | input | 5 | Requested mode code |
| cur_mode | output | 5 | Current mode code |
| mode_err | output | 1 | Invalid mode code was requested last cycle |
| saved_we | input | 1 | Saved status write enable |
| saved_wdata | input | DATA_W | Saved status write data |
| saved_rdata | output | DATA_W | Saved status of the current mode |

## Verification
The swap logic is tried with a walk through the modes that mixes three kinds of transition. One kind shares every bank (User to System). One kind shares only the R8–R12 copy (IRQ to User). One kind shares nothing (System to FIQ). Distinct marker values in every slot show which bank a value came from. A return visit to each mode tells private storage apart from a fresh load. The user-view port is exercised from FIQ and from User, so the redirect is separated from the plain active path. Stimuli that combine a mode request with writes, or name the current mode or an unknown code, separate the dropped write from the applied one.

// File: rtl/bank_pkg.sv
package bank_pkg;

    localparam int NREG      = 16;
    localparam int AW        = $clog2(NREG);
    localparam int FAST_LO   = 8;
    localparam int FAST_CNT  = 5;
    localparam int STACK_LO  = FAST_LO + FAST_CNT;
    localparam int STACK_CNT = 2;
    localparam int LIVE_CNT  = FAST_CNT + STACK_CNT;
    localparam int STACK_SLOTS = 6;
    localparam int PSR_SLOTS   = 5;
    localparam int FAST_SLOTS  = 2;
    localparam int STACK_SW  = $clog2(STACK_SLOTS);
    localparam int PSR_SW    = $clog2(PSR_SLOTS);
    localparam int FAST_SW   = $clog2(FAST_SLOTS);

    localparam logic [4:0] PM_USER  = 5'b10000;
    localparam logic [4:0] PM_FAST  = 5'b10001;
    localparam logic [4:0] PM_INTR  = 5'b10010;
    localparam logic [4:0] PM_SUPV  = 5'b10011;
    localparam logic [4:0] PM_ABRT  = 5'b10111;
    localparam logic [4:0] PM_UNDEF = 5'b11011;
    localparam logic [4:0] PM_SYST  = 5'b11111;

    typedef struct packed {
        logic [STACK_SW-1:0] stack_slot;
        logic [FAST_SW-1:0]  fast_slot;
        logic [PSR_SW-1:0]   psr_slot;
        logic                has_psr;
    } bank_sel_t;

    function automatic logic mode_ok(input logic [4:0] code);
        case (code)
            PM_USER, PM_FAST, PM_INTR, PM_SUPV,
            PM_ABRT, PM_UNDEF, PM_SYST: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

    function automatic bank_sel_t decode_sel(input logic [4:0] code);
        bank_sel_t s;
        s = '0;
        case (code)
            PM_SUPV:  begin s.stack_slot = 3'd1; s.psr_slot = 3'd0; s.has_psr = 1'b1; end
            PM_ABRT:  begin s.stack_slot = 3'd2; s.psr_slot = 3'd1; s.has_psr = 1'b1; end
            PM_UNDEF: begin s.stack_slot = 3'd3; s.psr_slot = 3'd2; s.has_psr = 1'b1; end
            PM_INTR:  begin s.stack_slot = 3'd4; s.psr_slot = 3'd3; s.has_psr = 1'b1; end
            PM_FAST:  begin s.stack_slot = 3'd5; s.psr_slot = 3'd4; s.has_psr = 1'b1;
                            s.fast_slot = 1'b1; end
            default:  s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/shadow_slots.sv
module shadow_slots #(
    parameter int W     = 32,
    parameter int SLOTS = 6,
    parameter int WORDS = 2,
    localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [SW-1:0]              wr_slot,
    input  logic [WORDS-1:0]           wr_mask,
    input  logic [WORDS-1:0][W-1:0]    wr_words,
    input  logic [SW-1:0]              rd_slot,
    output logic [WORDS-1:0][W-1:0]    rd_words,
    output logic [WORDS-1:0][W-1:0]    home_words
);
    localparam int DEPTH = 1 << SW;

    logic [WORDS-1:0][W-1:0] mem [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[s][w] <= '0;
                end else if (we && wr_slot == SW'(s) && wr_mask[w]) begin
                    mem[s][w] <= wr_words[w];
                end
            end
        end
    end

    assign rd_words   = mem[rd_slot];
    assign home_words = mem[0];

endmodule

// File: rtl/active_file.sv
module active_file #(
    parameter int W     = 32,
    parameter int N     = 16,
    parameter int BASE  = 8,
    parameter int NLOAD = 7,
    localparam int AW   = $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_en,
    input  logic [NLOAD-1:0][W-1:0] load_words,
    output logic [NLOAD-1:0][W-1:0] live_words,
    input  logic                    wa_en,
    input  logic [AW-1:0]           wa_addr,
    input  logic [W-1:0]            wa_data,
    input  logic                    wb_en,
    input  logic [AW-1:0]           wb_addr,
    input  logic [W-1:0]            wb_data,
    input  logic [AW-1:0]           ra_addr,
    output logic [W-1:0]            ra_data,
    input  logic [AW-1:0]           rb_addr,
    output logic [W-1:0]            rb_data,
    input  logic [AW-1:0]           rc_addr,
    output logic [W-1:0]            rc_data
);
    logic [W-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        if (i >= BASE && i < BASE + NLOAD) begin : g_banked
            always_ff @(posedge clk) begin
                if (rst)                                   regs[i] <= '0;
                else if (load_en)                          regs[i] <= load_words[i-BASE];
                else if (wa_en && wa_addr == AW'(i))       regs[i] <= wa_data;
                else if (wb_en && wb_addr == AW'(i))       regs[i] <= wb_data;
            end
            assign live_words[i-BASE] = regs[i];
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)                                   regs[i] <= '0;
                else if (wa_en && wa_addr == AW'(i))       regs[i] <= wa_data;
                else if (wb_en && wb_addr == AW'(i))       regs[i] <= wb_data;
            end
        end
    end

    assign ra_data = regs[ra_addr];
    assign rb_data = regs[rb_addr];
    assign rc_data = regs[rc_addr];

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [3:0]        rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [3:0]        usr_addr,
    input  logic              usr_we,
    input  logic [DATA_W-1:0] usr_wdata,
    output logic [DATA_W-1:0] usr_rdata,
    input  logic              mode_req,
    input  logic [4:0]        mode_code,
    output logic [4:0]        cur_mode,
    output logic              mode_err,
    input  logic              saved_we,
    input  logic [DATA_W-1:0] saved_wdata,
    output logic [DATA_W-1:0] saved_rdata
);
    logic [4:0]        mode_q;
    logic              err_q;
    logic [DATA_W-1:0] psr_q;

    bank_sel_t sel_cur, sel_new;
    logic      req_ok, swap, wr_allow, unpriv_view;

    logic [LIVE_CNT-1:0][DATA_W-1:0] live, load;

    // fast-interrupt copy of R8..R12
    logic                              f_we;
    logic [FAST_SW-1:0]                f_slot;
    logic [FAST_CNT-1:0]               f_mask;
    logic [FAST_CNT-1:0][DATA_W-1:0]   f_wwords, f_rd, f_home;

    // R13/R14 stack pairs
    logic                              h_we;
    logic [STACK_SW-1:0]               h_slot;
    logic [STACK_CNT-1:0]              h_mask;
    logic [STACK_CNT-1:0][DATA_W-1:0]  h_wwords, h_rd, h_home;

    // saved status words
    logic                              p_we;
    logic [0:0][DATA_W-1:0]            p_wwords, p_rd, p_home;

    logic       in_fast_rng, in_stack_rng, to_fast_copy, to_stack_pair;
    logic [3:0] off_fast, off_stack;
    logic       act_usr_we;
    logic [DATA_W-1:0] act_usr_rd;

    assign sel_cur     = decode_sel(mode_q);
    assign sel_new     = decode_sel(mode_code);
    assign req_ok      = mode_ok(mode_code);
    assign swap        = mode_req && req_ok && (mode_code != mode_q);
    assign wr_allow    = !mode_req;
    assign unpriv_view = !sel_cur.has_psr;

    assign in_fast_rng   = (usr_addr >= 4'(FAST_LO)) && (usr_addr < 4'(STACK_LO));
    assign in_stack_rng  = (usr_addr >= 4'(STACK_LO)) && (usr_addr < 4'(STACK_LO + STACK_CNT));
    assign to_fast_copy  = in_fast_rng && sel_cur.fast_slot[0];
    assign to_stack_pair = in_stack_rng && !unpriv_view;
    assign off_fast      = usr_addr - 4'(FAST_LO);
    assign off_stack     = usr_addr - 4'(STACK_LO);
    assign act_usr_we    = usr_we && wr_allow && !to_fast_copy && !to_stack_pair;

    always_comb begin
        f_we     = swap || (usr_we && wr_allow && to_fast_copy);
        f_slot   = swap ? sel_cur.fast_slot : '0;
        f_mask   = swap ? '1 : FAST_CNT'(1) << off_fast[2:0];
        for (int k = 0; k < FAST_CNT; k++) begin
            f_wwords[k] = swap ? live[k] : usr_wdata;
        end

        h_we     = swap || (usr_we && wr_allow && to_stack_pair);
        h_slot   = swap ? sel_cur.stack_slot : '0;
        h_mask   = swap ? '1 : STACK_CNT'(1) << off_stack[0];
        for (int k = 0; k < STACK_CNT; k++) begin
            h_wwords[k] = swap ? live[FAST_CNT+k] : usr_wdata;
        end

        p_we        = swap && sel_cur.has_psr;
        p_wwords[0] = psr_q;
    end

    // Incoming view: when both modes share a slot, the live value is the newest copy.
    always_comb begin
        for (int k = 0; k < FAST_CNT; k++) begin
            load[k] = (sel_new.fast_slot == sel_cur.fast_slot) ? live[k] : f_rd[k];
        end
        for (int k = 0; k < STACK_CNT; k++) begin
            load[FAST_CNT+k] = (sel_new.stack_slot == sel_cur.stack_slot)
                             ? live[FAST_CNT+k] : h_rd[k];
        end
    end

    shadow_slots #(.W(DATA_W), .SLOTS(FAST_SLOTS), .WORDS(FAST_CNT)) u_fast (
        .clk(clk), .rst(rst), .we(f_we), .wr_slot(f_slot), .wr_mask(f_mask),
        .wr_words(f_wwords), .rd_slot(sel_new.fast_slot), .rd_words(f_rd),
        .home_words(f_home)
    );

    shadow_slots #(.W(DATA_W), .SLOTS(STACK_SLOTS), .WORDS(STACK_CNT)) u_stack (
        .clk(clk), .rst(rst), .we(h_we), .wr_slot(h_slot), .wr_mask(h_mask),
        .wr_words(h_wwords), .rd_slot(sel_new.stack_slot), .rd_words(h_rd),
        .home_words(h_home)
    );

    shadow_slots #(.W(DATA_W), .SLOTS(PSR_SLOTS), .WORDS(1)) u_psr (
        .clk(clk), .rst(rst), .we(p_we), .wr_slot(sel_cur.psr_slot), .wr_mask(1'b1),
        .wr_words(p_wwords), .rd_slot(sel_new.psr_slot), .rd_words(p_rd),
        .home_words(p_home)
    );

    active_file #(.W(DATA_W), .N(NREG), .BASE(FAST_LO), .NLOAD(LIVE_CNT)) u_act (
        .clk(clk), .rst(rst),
        .load_en(swap), .load_words(load), .live_words(live),
        .wa_en(wr_en && wr_allow), .wa_addr(wr_addr), .wa_data(wr_data),
        .wb_en(act_usr_we), .wb_addr(usr_addr), .wb_data(usr_wdata),
        .ra_addr(rd_addr_a), .ra_data(rd_data_a),
        .rb_addr(rd_addr_b), .rb_data(rd_data_b),
        .rc_addr(usr_addr), .rc_data(act_usr_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_SYST;
            err_q  <= 1'b0;
            psr_q  <= '0;
        end else begin
            err_q <= mode_req && !req_ok;
            if (swap) begin
                mode_q <= mode_code;
                psr_q  <= sel_new.has_psr ? p_rd[0] : '0;
            end else if (saved_we && wr_allow && sel_cur.has_psr) begin
                psr_q  <= saved_wdata;
            end
        end
    end

    always_comb begin
        if (to_fast_copy)       usr_rdata = f_home[off_fast[2:0]];
        else if (to_stack_pair) usr_rdata = h_home[off_stack[0]];
        else                    usr_rdata = act_usr_rd;
    end

    assign cur_mode    = mode_q;
    assign mode_err    = err_q;
    assign saved_rdata = sel_cur.has_psr ? psr_q : '0;

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
    import bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_req,
    input logic [4:0]        mode_code,
    input logic [4:0]        cur_mode,
    input logic              mode_err,
    input logic [DATA_W-1:0] saved_rdata,
    input logic [3:0]        usr_addr,
    input logic [DATA_W-1:0] usr_rdata,
    input logic [3:0]        rd_addr_a,
    input logic [DATA_W-1:0] rd_data_a
);
    // R3
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        mode_ok(cur_mode));

    // R3
    mode_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_req && mode_ok(mode_code)) |=> (cur_mode == $past(mode_code)));

    // R7
    bad_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_req && !mode_ok(mode_code)) |=> ($stable(cur_mode) && mode_err));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> ($past(mode_req) && !mode_ok($past(mode_code))));

    // R12
    same_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_req && mode_code == cur_mode) |=> ($stable(cur_mode) && !mode_err));

    // R6
    no_saved_unpriv_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == PM_USER || cur_mode == PM_SYST) |-> (saved_rdata == '0));

    // R10
    user_view_plain_chk: assert property (@(posedge clk) disable iff (rst)
        (usr_addr < 4'd8 || usr_addr == 4'd15) && (usr_addr == rd_addr_a)
        |-> (usr_rdata == rd_data_a));

endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .mode_req(mode_req), .mode_code(mode_code),
    .cur_mode(cur_mode), .mode_err(mode_err), .saved_rdata(saved_rdata),
    .usr_addr(usr_addr), .usr_rdata(usr_rdata),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a)
);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
    localparam int W = 32;
    localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                           M_SVC = 5'b10011, M_ABT = 5'b10111, M_SYS = 5'b11111;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0, usr_addr = '0;
    logic [W-1:0] rd_data_a, rd_data_b, wr_data = '0, usr_wdata = '0, usr_rdata;
    logic wr_en = 1'b0, usr_we = 1'b0, mode_req = 1'b0, saved_we = 1'b0;
    logic [4:0] mode_code = '0, cur_mode;
    logic mode_err;
    logic [W-1:0] saved_wdata = '0, saved_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    banked_regfile #(.DATA_W(W)) u0 (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .usr_addr(usr_addr), .usr_we(usr_we), .usr_wdata(usr_wdata), .usr_rdata(usr_rdata),
        .mode_req(mode_req), .mode_code(mode_code), .cur_mode(cur_mode), .mode_err(mode_err),
        .saved_we(saved_we), .saved_wdata(saved_wdata), .saved_rdata(saved_rdata)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input int r, input logic [W-1:0] exp);
        rd_addr_a = 4'(r);
        rd_addr_b = 4'(15 - r);
        #1;
        chk(tag, rd_data_a, exp);
        rd_addr_b = 4'(r);
        #1;
        chk(tag, rd_data_b, exp);
    endtask

    task automatic chk_usr(input string tag, input int r, input logic [W-1:0] exp);
        usr_addr = 4'(r);
        #1;
        chk(tag, usr_rdata, exp);
    endtask

    task automatic do_write(input int r, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(r); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_uwrite(input int r, input logic [W-1:0] d);
        @(negedge clk);
        usr_we = 1'b1; usr_addr = 4'(r); usr_wdata = d;
        @(negedge clk);
        usr_we = 1'b0;
    endtask

    task automatic do_saved(input logic [W-1:0] d);
        @(negedge clk);
        saved_we = 1'b1; saved_wdata = d;
        @(negedge clk);
        saved_we = 1'b0;
    endtask

    task automatic do_mode(input logic [4:0] code);
        @(negedge clk);
        mode_req = 1'b1; mode_code = code;
        @(negedge clk);
        mode_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mode after reset", W'(cur_mode), W'(M_SYS));
        chk("R1 mode_err after reset", W'(mode_err), '0);
        chk("R1 saved after reset", saved_rdata, '0);
        for (int r = 0; r < 16; r++) chk_reg("R1 register zero", r, '0);
    endtask

    task automatic t_basic();
        for (int r = 0; r < 16; r++) do_write(r, 32'h1000_0000 + 32'(r) * 32'h111);
        for (int r = 0; r < 16; r++) chk_reg("R2 write/read", r, 32'h1000_0000 + 32'(r) * 32'h111);
    endtask

    task automatic t_banks();
        for (int r = 8; r < 13; r++) do_write(r, 32'hA000_0000 + 32'(r));
        do_write(13, 32'h5A5A_0013);
        do_write(14, 32'h5A5A_0014);
        do_mode(M_FIQ);
        chk("R3 mode now FIQ", W'(cur_mode), W'(M_FIQ));
        chk_reg("R5 FIQ r8 private fresh", 8, '0);
        chk_reg("R5 FIQ r12 private fresh", 12, '0);
        chk_reg("R4 FIQ r13 fresh", 13, '0);
        chk_reg("R4 FIQ r14 fresh", 14, '0);
        chk_reg("R5 FIQ r7 unbanked", 7, 32'h1000_0777);
        do_write(8, 32'hF000_0008);
        do_write(13, 32'hF000_0013);
        do_mode(M_IRQ);
        chk_reg("R5 IRQ sees shared r8", 8, 32'hA000_0008);
        chk_reg("R4 IRQ r13 fresh", 13, '0);
        do_write(13, 32'h1A1A_0013);
        do_mode(M_USR);
        chk_reg("R4 User shares System r13", 13, 32'h5A5A_0013);
        chk_reg("R4 User shares System r14", 14, 32'h5A5A_0014);
        chk_reg("R5 User r8 shared", 8, 32'hA000_0008);
        do_mode(M_FIQ);
        chk_reg("R5 FIQ r8 kept", 8, 32'hF000_0008);
        chk_reg("R4 FIQ r13 kept", 13, 32'hF000_0013);
        do_mode(M_IRQ);
        chk_reg("R4 IRQ r13 kept", 13, 32'h1A1A_0013);
        do_mode(M_SYS);
        chk_reg("R4 System r13 back", 13, 32'h5A5A_0013);
        do_mode(M_SYS);
        chk("R12 same-mode request mode", W'(cur_mode), W'(M_SYS));
        chk("R12 same-mode request no error", W'(mode_err), '0);
        chk_reg("R12 same-mode request r13", 13, 32'h5A5A_0013);
        chk_reg("R12 same-mode request r8", 8, 32'hA000_0008);
    endtask

    task automatic t_saved();
        do_saved(32'hBEEF_0000);
        chk("R6 System saved stays zero", saved_rdata, '0);
        do_mode(M_SVC);
        chk("R6 Supervisor saved fresh", saved_rdata, '0);
        do_saved(32'hC0DE_0001);
        chk("R6 Supervisor saved write", saved_rdata, 32'hC0DE_0001);
        do_mode(M_ABT);
        chk("R6 Abort saved fresh", saved_rdata, '0);
        do_saved(32'hC0DE_0002);
        do_mode(M_SVC);
        chk("R6 Supervisor saved kept", saved_rdata, 32'hC0DE_0001);
        do_mode(M_ABT);
        chk("R6 Abort saved kept", saved_rdata, 32'hC0DE_0002);
        do_mode(M_USR);
        chk("R6 User saved zero", saved_rdata, '0);
        do_mode(M_SYS);
    endtask

    task automatic t_invalid();
        do_mode(5'b00000);
        chk("R7 error raised", W'(mode_err), 32'd1);
        chk("R7 mode unchanged", W'(cur_mode), W'(M_SYS));
        chk_reg("R7 r13 unchanged", 13, 32'h5A5A_0013);
        @(negedge clk);
        chk("R7 error one cycle", W'(mode_err), '0);
        do_mode(5'b10100);
        chk("R7 error raised again", W'(mode_err), 32'd1);
        chk("R7 mode unchanged again", W'(cur_mode), W'(M_SYS));
        chk_reg("R7 r8 unchanged", 8, 32'hA000_0008);
    endtask

    task automatic t_userview();
        do_mode(M_FIQ);
        chk_usr("R8 FIQ user-view r13", 13, 32'h5A5A_0013);
        chk_usr("R9 FIQ user-view r8", 8, 32'hA000_0008);
        chk_reg("R9 FIQ active r8", 8, 32'hF000_0008);
        do_uwrite(13, 32'h0BAD_0013);
        do_uwrite(9, 32'h0BAD_0009);
        chk_reg("R8 FIQ active r13 untouched", 13, 32'hF000_0013);
        chk_reg("R9 FIQ active r9 untouched", 9, '0);
        do_mode(M_USR);
        chk_reg("R8 user-view write reached User r13", 13, 32'h0BAD_0013);
        chk_reg("R9 user-view write reached shared r9", 9, 32'h0BAD_0009);
        do_uwrite(13, 32'h7777_0013);
        chk_reg("R8 User user-view write active", 13, 32'h7777_0013);
        chk_usr("R9 User user-view r8 active", 8, 32'hA000_0008);
        chk_usr("R10 user-view r3", 3, 32'h1000_0333);
        chk_usr("R10 user-view r15", 15, 32'h1000_0FFF);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd5; wr_data = 32'h1111_0005;
        usr_we = 1'b1; usr_addr = 4'd5; usr_wdata = 32'h2222_0005;
        @(negedge clk);
        wr_en = 1'b0; usr_we = 1'b0;
        chk_reg("R10 write port wins", 5, 32'h1111_0005);
    endtask

    task automatic t_wr_ignore();
        @(negedge clk);
        mode_req = 1'b1; mode_code = M_USR;
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'hDEAD_0000;
        usr_we = 1'b1; usr_addr = 4'd1; usr_wdata = 32'hDEAD_0001;
        @(negedge clk);
        mode_req = 1'b0; wr_en = 1'b0; usr_we = 1'b0;
        chk_reg("R11 write port dropped", 0, 32'h1000_0000);
        chk_reg("R11 user-view write dropped", 1, 32'h1000_0111);
        @(negedge clk);
        mode_req = 1'b1; mode_code = M_SVC;
        wr_en = 1'b1; wr_addr = 4'd13; wr_data = 32'hDEAD_0013;
        saved_we = 1'b1; saved_wdata = 32'hDEAD_5555;
        @(negedge clk);
        mode_req = 1'b0; wr_en = 1'b0; saved_we = 1'b0;
        chk("R3 mode now Supervisor", W'(cur_mode), W'(M_SVC));
        chk_reg("R11 swap-cycle write dropped", 13, '0);
        chk("R11 saved write dropped", saved_rdata, 32'hC0DE_0001);
        do_mode(M_USR);
        chk_reg("R11 User r13 intact", 13, 32'h7777_0013);
        do_mode(M_SYS);
        chk_reg("R4 System sees User r13", 13, 32'h7777_0013);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_banks();
        t_saved();
        t_invalid();
        t_userview();
        t_wr_ignore();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule